// File: doc/BRIEF.md
# Video sync rate meter

This block measures the repetition rates of a horizontal and a vertical sync line and reports each as a 10-bit count. It runs from a 4 MHz system clock. The horizontal rate is the number of H sync rising edges that fall inside a fixed gate of 20 000 clock cycles (5 ms). At that gate length the count equals the line rate in kHz times 5 ms, so a 31.5 kHz line rate gives 157 (0x9D).

The vertical rate works the other way round. A reference tick is made by dividing the clock by 128, which gives 31.25 kHz and a 32 µs step. The block counts these ticks from one V sync rising edge to the next, so 60 Hz gives 520 (0x208) and 50 Hz gives 625 (0x271). When V sync stops, a nominal value for the frame rate chosen by a select input is reported.

A dummy-sync mode freezes both results while the display runs from internally generated timing. Both sync inputs pass through two-flop synchronizers. Each result register changes only when its own measurement completes.

Top module: `sync_rate_meter`

## Requirements
- R1: While reset is held and in the cycle after it is released, the H count reads 0 and the V count reads the nominal value selected by the rate select (0 selects 520, 1 selects 625).
- R2: Every GATE_CYC clock cycles (default 20 000) the H count is loaded with the number of synchronized H rising edges that fell within that gate. An edge that arrives in the gate's closing cycle counts in that gate. Between gate ends the H count holds its value.
- R3: An H count that would exceed 1023 reads 1023.
- R4: A gate with no H rising edge, whether the line is held low or held high, gives an H count of 0.
- R5: The V count is loaded, at a V rising edge, with the number of reference ticks (one every REF_DIV cycles, default 128) in the cycles since the previous V rising edge, that edge's own cycle included. The first V edge after reset, after a timeout or after dummy mode only starts a measurement and leaves the V count unchanged.
- R6: If 1023 ticks pass without a V edge and one more tick then arrives, the V count is loaded with the nominal value: 520 when the rate select is 0 and 625 when it is 1. This repeats for as long as V sync stays absent.
- R7: While dummy mode is 1, neither count changes, whatever arrives on the sync lines. After dummy mode returns to 0, both measurements restart from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4 MHz system clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| dummy_i | input | 1 | 1 = dummy sync mode, measurement frozen |
| vsel_i | input | 1 | Nominal frame rate for absent V: 0 = 60 Hz, 1 = 50 Hz |
| hcount_o | output | 10 | Measured H edges per gate |
| vcount_o | output | 10 | Measured reference ticks per V period |

## Verification
An H rising edge can land in the same cycle that closes the gate. In the same way, a V rising edge can land in the same cycle as a reference tick. The bench provokes both with periodic pulses whose period divides the gate length, or is a multiple of the tick period, and gives each pulse train a random phase. Over any phase, such a train puts exactly the same number of events in every window. A coincident event that is lost or counted twice therefore moves the result by one away from the exact value the bench computes.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int unsigned SRM_CNT_W = 10;

  typedef enum logic {
    SRM_RATE_60 = 1'b0,
    SRM_RATE_50 = 1'b1
  } srm_rate_e;
endpackage

// File: rtl/srm_sync_rise.sv
module srm_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic rise_o
);
  // STAGES flops for metastability, one more to detect the edge
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) pipe_q <= '0;
    else       pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/srm_h_meter.sv
module srm_h_meter #(
  parameter int CNT_W    = 10,
  parameter int GATE_CYC = 20000
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             freeze_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int GW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [GW-1:0]    GLAST = GW'(GATE_CYC - 1);

  logic [GW-1:0]    gate_q;
  logic [CNT_W-1:0] acc_q, sum;

  // The edge of the closing cycle is folded into the result
  assign sum    = (rise_i && acc_q != CMAX) ? acc_q + CNT_W'(1) : acc_q;
  assign done_o = !freeze_i && (gate_q == GLAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || freeze_i) begin
      gate_q <= '0;
      acc_q  <= '0;
    end else if (done_o) begin
      gate_q <= '0;
      acc_q  <= '0;
    end else begin
      gate_q <= gate_q + GW'(1);
      acc_q  <= sum;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       count_o <= '0;
    else if (done_o) count_o <= sum;
  end
endmodule

// File: rtl/srm_v_meter.sv
module srm_v_meter #(
  parameter int CNT_W   = 10,
  parameter int REF_DIV = 128
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             freeze_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] nom_i,
  output logic             armed_o,
  output logic             tmo_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int DW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [DW-1:0]    DLAST = DW'(REF_DIV - 1);

  logic [DW-1:0]    div_q;
  logic             tick;
  logic [CNT_W-1:0] acc_q, sum;
  logic             armed_q;

  assign tick    = (div_q == DLAST);
  assign sum     = (tick && acc_q != CMAX) ? acc_q + CNT_W'(1) : acc_q;
  // A V edge takes priority over a timeout landing in the same cycle
  assign tmo_o   = !freeze_i && !rise_i && tick && (acc_q == CMAX);
  assign armed_o = armed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || freeze_i) begin
      div_q   <= '0;
      acc_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (rise_i) begin
        acc_q   <= '0;
        armed_q <= 1'b1;
      end else if (tmo_o) begin
        acc_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        acc_q <= sum;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                               count_o <= nom_i;
    else if (!freeze_i && rise_i && armed_q) count_o <= sum;
    else if (tmo_o)                          count_o <= nom_i;
  end
endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter #(
  parameter int CNT_W    = srm_pkg::SRM_CNT_W,
  parameter int GATE_CYC = 20000,
  parameter int REF_DIV  = 128,
  parameter int V_NOM_60 = 520,
  parameter int V_NOM_50 = 625
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             dummy_i,
  input  logic             vsel_i,
  output logic [CNT_W-1:0] hcount_o,
  output logic [CNT_W-1:0] vcount_o
);
  import srm_pkg::*;

  logic [1:0]       raw_sync, rise;
  logic             h_done, v_tmo, v_armed, v_rise;
  logic [CNT_W-1:0] v_nom;

  assign raw_sync = {vsync_i, hsync_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    srm_sync_rise #(.STAGES(2)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (raw_sync[g]),
      .rise_o(rise[g])
    );
  end

  assign v_rise = rise[1];
  assign v_nom  = (vsel_i == SRM_RATE_50) ? CNT_W'(V_NOM_50) : CNT_W'(V_NOM_60);

  srm_h_meter #(.CNT_W(CNT_W), .GATE_CYC(GATE_CYC)) u_h (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .freeze_i(dummy_i),
    .rise_i  (rise[0]),
    .done_o  (h_done),
    .count_o (hcount_o)
  );

  srm_v_meter #(.CNT_W(CNT_W), .REF_DIV(REF_DIV)) u_v (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .freeze_i(dummy_i),
    .rise_i  (v_rise),
    .nom_i   (v_nom),
    .armed_o (v_armed),
    .tmo_o   (v_tmo),
    .count_o (vcount_o)
  );
endmodule

// File: rtl/srm_chk.sv
module srm_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             dummy_i,
  input logic [CNT_W-1:0] hcount_o,
  input logic [CNT_W-1:0] vcount_o,
  input logic [CNT_W-1:0] v_nom,
  input logic             h_done,
  input logic             v_tmo,
  input logic             v_rise,
  input logic             v_armed
);
  a_r7_dummy_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    dummy_i |=> ($stable(hcount_o) && $stable(vcount_o)));

  a_r2_h_only_at_gate: assert property (@(posedge clk_i) disable iff (rst_i)
    !h_done |=> $stable(hcount_o));

  a_r6_timeout_load: assert property (@(posedge clk_i) disable iff (rst_i)
    v_tmo |=> (vcount_o == $past(v_nom)));

  a_r5_first_edge_arms: assert property (@(posedge clk_i) disable iff (rst_i)
    (v_rise && !v_armed) |=> $stable(vcount_o));
endmodule

bind sync_rate_meter srm_chk u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .dummy_i (dummy_i),
  .hcount_o(hcount_o),
  .vcount_o(vcount_o),
  .v_nom   (v_nom),
  .h_done  (h_done),
  .v_tmo   (v_tmo),
  .v_rise  (v_rise),
  .v_armed (v_armed)
);

// File: tb/sync_rate_meter_tb_top.sv
module sync_rate_meter_tb_top;
  localparam int GATE = 2400;
  localparam int DIV  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync = 1'b0, vsync = 1'b0, dummy = 1'b0, vsel = 1'b0;
  logic [9:0] hcount, vcount;

  int nchk = 0, nerr = 0;
  int hper = 0, hph = 0, vper = 0, vph = 0;
  logic hidle = 1'b0;

  always #2 clk = ~clk;

  sync_rate_meter #(.GATE_CYC(GATE), .REF_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_i(rst), .hsync_i(hsync), .vsync_i(vsync),
    .dummy_i(dummy), .vsel_i(vsel), .hcount_o(hcount), .vcount_o(vcount)
  );

  // Pulse generators: one-cycle-wide pulses every hper / vper cycles
  initial forever begin
    @(negedge clk);
    if (hper == 0) hsync = hidle;
    else begin hph = (hph + 1) % hper; hsync = (hph == 0); end
    if (vper == 0) vsync = 1'b0;
    else begin vph = (vph + 1) % vper; vsync = (vph == 0); end
  end

  function automatic int exp_h(int per);
    if (per == 0) return 0;
    return (GATE / per > 1023) ? 1023 : GATE / per;
  endfunction

  function automatic int nominal(logic sel);
    return sel ? 625 : 520;
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_rates(int hp, int vp);
    hper = hp; hph = (hp > 0) ? int'($urandom % hp) : 0;
    vper = vp; vph = (vp > 0) ? int'($urandom % vp) : 0;
  endtask

  task automatic settle(int vp);
    int w = 2 * GATE + 10;
    if (3 * vp + 20 > w) w = 3 * vp + 20;
    wait_cyc(w);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    wait_cyc(5);
    check("R1 hcount in reset", int'(hcount), 0);
    check("R1 vcount in reset", int'(vcount), 520);
    rst = 1'b0;
    wait_cyc(1);
    check("R1 hcount after reset", int'(hcount), 0);
    check("R1 vcount after reset", int'(vcount), 520);

    // Directed: 80 edges per gate, V at 520 ticks
    set_rates(30, 520 * DIV); settle(520 * DIV);
    check("R2 h period 30", int'(hcount), 80);
    check("R5 v 520 ticks", int'(vcount), 520);

    // Saturation of H, V at its largest count before timeout
    set_rates(2, 1023 * DIV); settle(1023 * DIV);
    check("R3 h saturated", int'(hcount), 1023);
    check("R5 v 1023 ticks", int'(vcount), 1023);

    // Random periods with random phase
    for (int i = 0; i < 6; i++) begin
      int hp, k;
      do hp = 2 + int'($urandom % 150); while (GATE % hp != 0);
      k = 50 + int'($urandom % 550);
      set_rates(hp, k * DIV); settle(k * DIV);
      check("R2 random h", int'(hcount), exp_h(hp));
      check("R5 random v", int'(vcount), k);
    end

    // No H, line low then high; no V gives nominal
    hidle = 1'b0; set_rates(0, 0); wait_cyc(2 * GATE + 10);
    check("R4 h absent low", int'(hcount), 0);
    hidle = 1'b1; wait_cyc(2 * GATE + 10);
    check("R4 h stuck high", int'(hcount), 0);
    check("R6 v nominal sel0", int'(vcount), nominal(1'b0));
    vsel = 1'b1; wait_cyc(1030 * DIV + 20);
    check("R6 v nominal sel1", int'(vcount), nominal(1'b1));

    // First V edge only arms: pulse arrives at once, check before a second one
    hidle = 1'b0;
    vper = 300 * DIV; vph = vper - 1;
    wait_cyc(vper / 2);
    check("R5 first edge arms", int'(vcount), 625);
    wait_cyc(vper * 2);
    check("R5 after arming", int'(vcount), 300);

    // Dummy mode freezes both counts
    set_rates(30, 520 * DIV); settle(520 * DIV);
    check("R2 pre-dummy h", int'(hcount), 80);
    dummy = 1'b1;
    set_rates(10, 600 * DIV); wait_cyc(3 * GATE);
    check("R7 h frozen", int'(hcount), 80);
    check("R7 v frozen", int'(vcount), 520);
    set_rates(0, 0); wait_cyc(1100 * DIV);
    check("R7 v no timeout in dummy", int'(vcount), 520);
    dummy = 1'b0;
    set_rates(10, 600 * DIV); settle(600 * DIV);
    check("R7 h after release", int'(hcount), 240);
    check("R7 v after release", int'(vcount), 600);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule